// File: doc/BRIEF.md
# Shared-Line Interrupt Controller With Sublines

This controller gathers interrupt requests from devices that share a small set of request lines and still tells each device apart. There are NL request lines (16 by default), and every line is split into NS sublines (16 by default). A device owns one line/subline pair. It raises or lowers that pair through a command port that carries an 8-bit code. The code holds the subline number in its upper nibble and the line number in its lower nibble.

Each subline is edge-detected and keeps its own pending bit. A line takes part in arbitration when at least one of its sublines is pending, its mask bit is clear, and neither it nor any line of higher priority is in service. While such a line exists, the single request to the CPU is high. The CPU answers with an acknowledge pulse. The controller then reports the winning line and subline, sends a one-cycle acknowledge to that subline's device, clears the subline's pending bit, and marks the line and the subline as in service. An end-of-interrupt pulse retires the highest-priority interrupt in service. The device uses its acknowledge to set flags that software can read to identify it.

Top module: `shared_irq_ctrl`

## Requirements
- R1: A command with cmd_valid high applies to subline cmd_code[7:4] of line cmd_code[3:0]. cmd_raise=1 raises the subline and cmd_raise=0 lowers it.
- R2: Raising a subline that is currently lowered sets its pending bit. Raising a subline that is already raised sets nothing new, so it produces only one interrupt.
- R3: Lowering a subline after its pending bit is set does not clear that bit. Only the acknowledge of that subline clears it.
- R4: Writing mask_wdata with mask_we loads the mask register, which reads back on mask_q. Bit L set masks line L, and a masked line does not drive irq_out.
- R5: Priority is fixed. Line 0 is highest. Within a line, the lowest-numbered pending subline wins.
- R6: When ack_req is high in a cycle where irq_out is high, the next cycle carries ack_valid=1, ack_line and ack_sub of the winner, and a single dev_ack bit at index {sub,line}. All of these last one cycle.
- R7: An acknowledge sets in_service[line] and the subline's shadow bit, and clears only that subline's pending bit.
- R8: A line cannot request while it, or any line of higher priority, is in service. A line of higher priority can still interrupt.
- R9: An eoi pulse clears the lowest-numbered in_service bit and that line's shadow bits. Sublines still pending on that line then request again.
- R10: After reset, all pending, in-service and shadow state is clear, the mask is all zeros, and irq_out, ack_valid and dev_ack are low.
- R11: An ack_req while irq_out is low produces no acknowledge and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Raise/lower command strobe |
| cmd_raise | input | 1 | 1 raises, 0 lowers |
| cmd_code | input | 8 | {subline, line} code |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | NL | New mask value |
| mask_q | output | NL | Current mask |
| irq_out | output | 1 | Interrupt request to the CPU |
| ack_req | input | 1 | CPU acknowledge pulse |
| ack_valid | output | 1 | Acknowledge result valid (one cycle) |
| ack_line | output | 4 | Winning line |
| ack_sub | output | 4 | Winning subline |
| dev_ack | output | NL*NS | One-hot acknowledge to the winning subline's device |
| eoi | input | 1 | End-of-interrupt pulse |
| in_service | output | NL | In-service bit of each line |

## Verification
The assertions assume that ack_req and eoi are single-cycle pulses. They also assume that an eoi arrives only for an interrupt that was acknowledged, and that no raise command targets a subline in the same cycle that this subline is acknowledged. The stimulus drives every strobe for exactly one cycle. It keeps each raise/lower command apart from acknowledges, and it issues eoi only after a matching acknowledge. The assertions cover the one-hot acknowledge, its causal link to a request and to irq_out, the in-service marking, and the retirement done by eoi.

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl #(
  parameter int NL = 16,
  parameter int NS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_raise,
  input  logic [7:0]       cmd_code,
  input  logic             mask_we,
  input  logic [NL-1:0]    mask_wdata,
  output logic [NL-1:0]    mask_q,
  output logic             irq_out,
  input  logic             ack_req,
  output logic             ack_valid,
  output logic [3:0]       ack_line,
  output logic [3:0]       ack_sub,
  output logic [NL*NS-1:0] dev_ack,
  input  logic             eoi,
  output logic [NL-1:0]    in_service
);
  localparam int LW = $clog2(NL);
  localparam int SW = $clog2(NS);

  logic [NS-1:0][NL-1:0] lvl, pend, shadow;
  logic [NL-1:0] line_pend, elig;
  logic [LW-1:0] win_line, eoi_line;
  logic [SW-1:0] win_sub;
  logic          eoi_any, ack_fire;
  logic [LW-1:0] c_line;
  logic [SW-1:0] c_sub;

  assign c_line = cmd_code[LW-1:0];
  assign c_sub  = cmd_code[LW+SW-1:LW];

  always_comb begin
    logic blk, found;
    blk = 1'b0;
    for (int l = 0; l < NL; l++) begin
      line_pend[l] = 1'b0;
      for (int s = 0; s < NS; s++) line_pend[l] = line_pend[l] | pend[s][l];
      blk = blk | in_service[l];
      elig[l] = line_pend[l] & ~mask_q[l] & ~blk;
    end
    win_line = '0;
    found = 1'b0;
    for (int l = NL-1; l >= 0; l--)
      if (elig[l]) begin win_line = LW'(l); found = 1'b1; end
    win_sub = '0;
    for (int s = NS-1; s >= 0; s--)
      if (pend[s][win_line]) win_sub = SW'(s);
    eoi_line = '0;
    eoi_any = 1'b0;
    for (int l = NL-1; l >= 0; l--)
      if (in_service[l]) begin eoi_line = LW'(l); eoi_any = 1'b1; end
    irq_out = found;
  end

  assign ack_fire = ack_req & irq_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= '0; pend <= '0; shadow <= '0;
      in_service <= '0; mask_q <= '0;
      ack_valid <= 1'b0; ack_line <= '0; ack_sub <= '0; dev_ack <= '0;
    end else begin
      ack_valid <= ack_fire;
      dev_ack   <= '0;
      if (mask_we) mask_q <= mask_wdata;
      if (eoi && eoi_any) begin
        in_service[eoi_line] <= 1'b0;
        for (int s = 0; s < NS; s++) shadow[s][eoi_line] <= 1'b0;
      end
      if (ack_fire) begin
        ack_line <= 4'(win_line);
        ack_sub  <= 4'(win_sub);
        dev_ack[{win_sub, win_line}] <= 1'b1;
        pend[win_sub][win_line]   <= 1'b0;
        shadow[win_sub][win_line] <= 1'b1;
        in_service[win_line]      <= 1'b1;
      end
      if (cmd_valid) begin
        lvl[c_sub][c_line] <= cmd_raise;
        if (cmd_raise && !lvl[c_sub][c_line]) pend[c_sub][c_line] <= 1'b1;
      end
    end
  end

  assert_dev_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack));
  assert_ack_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ($past(ack_req) && $past(irq_out)));
  assert_ack_matches_dev_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> dev_ack[{ack_sub[SW-1:0], ack_line[LW-1:0]}]);
  assert_ack_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (in_service[ack_line[LW-1:0]] && shadow[ack_sub[SW-1:0]][ack_line[LW-1:0]]));
  assert_eoi_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_fire && in_service != '0) |=>
      ($countones(in_service) + 1 == $countones($past(in_service))));
endmodule

// File: tb/shared_irq_ctrl_bench.sv
`timescale 1ns/100ps
module shared_irq_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_raise = 0, mask_we = 0, ack_req = 0, eoi = 0;
  logic [7:0] cmd_code = 0;
  logic [15:0] mask_wdata = 0, mask_q, in_service;
  logic irq_out, ack_valid;
  logic [3:0] ack_line, ack_sub;
  logic [255:0] dev_ack;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shared_irq_ctrl u_shared_irq_ctrl (.*);

  // code, expected line, expected sub
  localparam logic [15:0] VEC [8] = '{
    16'h00_0_0, 16'hF0_0_F, 16'h0F_F_0, 16'hA5_5_A,
    16'h3C_C_3, 16'h71_1_7, 16'hFF_F_F, 16'h2E_E_2};

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic cmd(bit r, logic [7:0] c);
    cmd_valid = 1; cmd_raise = r; cmd_code = c; tick; cmd_valid = 0;
  endtask

  task automatic ack; ack_req = 1; tick; ack_req = 0; endtask
  task automatic do_eoi; eoi = 1; tick; eoi = 0; endtask

  task automatic ack_expect(string req, int ln, int sb);
    ack;
    chk(ack_valid == 1, req, ack_valid, 1);
    chk(ack_line == ln && ack_sub == sb, req, {ack_sub, ack_line}, {sb[3:0], ln[3:0]});
    chk(dev_ack == (256'b1 << {sb[3:0], ln[3:0]}), req, $countones(dev_ack), 1);
  endtask

  initial begin
    repeat (3) tick;
    // R10 reset state
    chk(irq_out == 0 && ack_valid == 0 && dev_ack == 0, "R10", irq_out, 0);
    chk(mask_q == 0 && in_service == 0, "R10", mask_q, 0);
    rst_n = 1; tick;

    // R11 acknowledge with nothing pending
    ack;
    chk(ack_valid == 0 && dev_ack == 0 && in_service == 0, "R11", ack_valid, 0);

    // R1/R6 vector walk
    foreach (VEC[i]) begin
      cmd(1, VEC[i][15:8]);
      chk(irq_out == 1, "R1", irq_out, 1);
      ack_expect("R1", VEC[i][7:4], VEC[i][3:0]);
      tick;
      chk(dev_ack == 0 && ack_valid == 0, "R6", $countones(dev_ack), 0);
      chk(in_service == (16'b1 << VEC[i][7:4]), "R7", in_service, 16'b1 << VEC[i][7:4]);
      do_eoi;
      chk(in_service == 0 && irq_out == 0, "R9", in_service, 0);
      cmd(0, VEC[i][15:8]);
    end

    // R2 repeated raise gives one interrupt
    cmd(1, 8'h31); cmd(1, 8'h31);
    ack_expect("R2", 1, 3);
    do_eoi;
    chk(irq_out == 0, "R2", irq_out, 0);
    cmd(0, 8'h31);

    // R3 lower after latch keeps pending
    cmd(1, 8'h52); cmd(0, 8'h52);
    chk(irq_out == 1, "R3", irq_out, 1);
    ack_expect("R3", 2, 5);
    do_eoi;

    // R5 priority, R9 re-request after eoi
    cmd(1, 8'h47); cmd(1, 8'h27); cmd(1, 8'h93);
    ack_expect("R5", 3, 9);
    do_eoi;
    ack_expect("R5", 7, 2);
    chk(irq_out == 0, "R8", irq_out, 0);
    do_eoi;
    chk(irq_out == 1, "R9", irq_out, 1);
    ack_expect("R5", 7, 4);
    do_eoi;
    cmd(0, 8'h47); cmd(0, 8'h27); cmd(0, 8'h93);

    // R4 mask
    mask_wdata = 16'h0040; mask_we = 1; tick; mask_we = 0;
    chk(mask_q == 16'h0040, "R4", mask_q, 16'h0040);
    cmd(1, 8'h06);
    chk(irq_out == 0, "R4", irq_out, 0);
    mask_wdata = 0; mask_we = 1; tick; mask_we = 0;
    chk(irq_out == 1, "R4", irq_out, 1);
    ack_expect("R4", 6, 0);
    do_eoi; cmd(0, 8'h06);

    // R8 blocking
    cmd(1, 8'h04);
    ack_expect("R8", 4, 0);
    cmd(1, 8'h08);
    chk(irq_out == 0, "R8", irq_out, 0);
    cmd(1, 8'h14);
    chk(irq_out == 0, "R8", irq_out, 0);
    cmd(1, 8'h01);
    chk(irq_out == 1, "R8", irq_out, 1);
    ack_expect("R8", 1, 0);
    do_eoi;
    chk(in_service == 16'h0010 && irq_out == 0, "R9", in_service, 16'h0010);
    do_eoi;
    chk(in_service == 0 && irq_out == 1, "R9", in_service, 0);
    ack_expect("R8", 4, 1);
    do_eoi;
    ack_expect("R8", 8, 0);
    do_eoi;
    chk(irq_out == 0 && in_service == 0, "R7", in_service, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule